// File: doc/BRIEF.md
# Bidirectional Mantissa Shifter

This block moves a 64-bit mantissa left or right by any distance from 0 to 64 bit positions in one pass. It feeds operand alignment ahead of an adder (right shifts, where the smaller operand is moved down) and normalization after it (left shifts, where leading zeros are pushed out). Leading-zero counting, exponent update and rounding are handled elsewhere.

The shift distance is split into two parts. Its upper bits select a coarse move by whole bytes. Its lower three bits then select a fine move of 0 to 7 bits. There is only one right-shifting network. A left shift bit-reverses the word on its way in and on its way out of that network.

On right shifts a sticky flag reports whether any 1 bit fell off the low end. Rounding logic downstream needs this flag. The result and the flag are registered once by default. A parameter can remove that register.

Top module: `mant_shifter`

## Requirements
- R1: With `go_left`=0 and `amount` in 0..63, `result` equals `operand` logically shifted right by `amount`, with zeros filled in at the top.
- R2: With `go_left`=1 and `amount` in 0..63, `result` equals `operand` logically shifted left by `amount`, with zeros filled in at the bottom.
- R3: For any `amount` from 64 to 127, `result` is all zeros in both directions.
- R4: With `go_left`=0, `sticky` is 1 exactly when at least one 1 bit of `operand` sits below bit position `amount`. For `amount` of 64 or more, this means any 1 bit of `operand`.
- R5: With `go_left`=1, `sticky` is 0 whatever the operand and amount.
- R6: With `amount`=0, `result` equals `operand` and `sticky` is 0 in both directions.
- R7: `go_left` alone selects the direction: 1 shifts toward the MSB and 0 shifts toward the LSB.
- R8: With the output register present (the default), `result` and `sticky` follow the inputs sampled at the previous rising clock edge. An active-low asynchronous reset clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| operand | input | 64 | Mantissa to be shifted |
| amount | input | 7 | Shift distance, 0..127 |
| go_left | input | 1 | 1 = shift left, 0 = shift right |
| result | output | 64 | Shifted mantissa |
| sticky | output | 1 | OR of the bits discarded by a right shift |

## Verification
The assertions take it for granted that `amount` and `go_left` are always driven to known values. They also assume that the registered output lags the combinational core by exactly one edge. For this reason the properties check the core's result and flag in the same cycle as the inputs.

The stimulus respects these assumptions. Inputs change only on falling edges and are held through the next rising edge. The bench sweeps every distance from 0 to 70, plus 127, in both directions, over fixed corner patterns and random words. It compares the outputs against the shift operators one cycle later.

// File: rtl/mant_shifter.sv
module mant_shifter #(
  parameter int W       = 64,
  parameter int REG_OUT = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [W-1:0]             operand,
  input  logic [$clog2(W):0]       amount,
  input  logic                     go_left,
  output logic [W-1:0]             result,
  output logic                     sticky
);
  localparam int AW = $clog2(W) + 1;
  localparam int FW = 3;
  localparam int CW = AW - FW;

  logic [W-1:0]  core_in, coarse, fine, core_res;
  logic [AW-1:0] coarse_amt, fine_amt;
  logic          lost_coarse, lost_fine, core_stk;

  for (genvar i = 0; i < W; i++) begin : g_rev_in
    assign core_in[i] = go_left ? operand[W-1-i] : operand[i];
  end

  assign coarse_amt  = {amount[AW-1:FW], {FW{1'b0}}};
  assign fine_amt    = {{CW{1'b0}}, amount[FW-1:0]};

  assign coarse      = core_in >> coarse_amt;
  assign lost_coarse = |(core_in & ~({W{1'b1}} << coarse_amt));
  assign fine        = coarse >> fine_amt;
  assign lost_fine   = |(coarse & ~({W{1'b1}} << fine_amt));

  for (genvar i = 0; i < W; i++) begin : g_rev_out
    assign core_res[i] = go_left ? fine[W-1-i] : fine[i];
  end

  assign core_stk = ~go_left & (lost_coarse | lost_fine);

  if (REG_OUT != 0) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        result <= '0;
        sticky <= 1'b0;
      end else begin
        result <= core_res;
        sticky <= core_stk;
      end
    end
  end else begin : g_comb
    assign result = core_res;
    assign sticky = core_stk;
  end
endmodule

// File: rtl/mant_shifter_chk.sv
module mant_shifter_chk #(
  parameter int W = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [W-1:0]         operand,
  input logic [$clog2(W):0]   amount,
  input logic                 go_left,
  input logic [W-1:0]         res,
  input logic                 stk
);
  assert_far_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (amount >= W) |-> (res == '0));

  assert_left_no_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    go_left |-> !stk);

  assert_zero_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (amount == 0) |-> (res == operand && !stk));

  assert_far_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!go_left && amount >= W) |-> (stk == (|operand)));

  assert_bits_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(res) <= $countones(operand)));

  assert_right_msb_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!go_left && amount != 0) |-> !res[W-1]);

  assert_left_lsb_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (go_left && amount != 0) |-> !res[0]);
endmodule

bind mant_shifter mant_shifter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .operand(operand), .amount(amount),
  .go_left(go_left), .res(core_res), .stk(core_stk)
);

// File: tb/mant_shifter_test.sv
module mant_shifter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] operand = '0;
  logic [6:0]  amount = '0;
  logic        go_left = 1'b0;
  logic [63:0] result;
  logic        sticky;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  mant_shifter uut (
    .clk(clk), .rst_n(rst_n), .operand(operand), .amount(amount),
    .go_left(go_left), .result(result), .sticky(sticky)
  );

  always #10 clk = ~clk;

  task automatic check(input logic [63:0] d, input int a, input logic l);
    logic [63:0] exp_r;
    logic        exp_s;
    @(negedge clk);
    operand = d; amount = 7'(a); go_left = l;
    if (a >= 64) begin
      exp_r = '0;
      exp_s = l ? 1'b0 : (|d);
    end else if (l) begin
      exp_r = d << a;
      exp_s = 1'b0;
    end else begin
      exp_r = d >> a;
      exp_s = |(d & ((64'd1 << a) - 64'd1));
    end
    @(posedge clk);
    @(negedge clk);
    tests++;
    if (result !== exp_r || sticky !== exp_s) begin
      fails++;
      $display("FAIL %s dir=%0d amt=%0d d=%h: got %h/%0b exp %h/%0b",
               a == 0 ? "R6" : (a >= 64 ? "R3/R4" : (l ? "R2/R5/R7" : "R1/R4/R7")),
               l, a, d, result, sticky, exp_r, exp_s);
    end
  endtask

  initial begin
    logic [63:0] pats [6];
    #35;
    tests++;
    if (result !== '0 || sticky !== 1'b0) begin
      fails++;
      $display("FAIL R8 reset: got %h/%0b exp 0/0", result, sticky);
    end
    @(negedge clk);
    rst_n = 1'b1;
    pats[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[1] = 64'h8000_0000_0000_0001;
    pats[2] = 64'h0;
    for (int k = 3; k < 6; k++) pats[k] = {$urandom(), $urandom()};
    for (int p = 0; p < 6; p++)
      for (int l = 0; l < 2; l++) begin
        for (int a = 0; a <= 70; a++) check(pats[p], a, l[0]);
        check(pats[p], 127, l[0]);
      end
    for (int b = 0; b < 64; b++) check(64'd1 << b, b, 1'b0);
    check(64'h1, 1, 1'b1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule